// File: doc/BRIEF.md
# Serial-Loaded Mode Register

This block holds the fourteen configuration bits of a run-length-limited write/read path. Software or a board controller loads it over three wires: a serial clock, a data line and a select line. While select is low, each rising serial-clock edge pushes one data bit into a staging shift register. While select is high, the staging register is copied in parallel into the output latch. The latch drives the decoded mode outputs. Because the two stages are separate, the path keeps running on its old settings while a new word is being shifted in.

The three serial wires arrive asynchronously. Each passes through a synchronizer on the block's system clock, and the serial clock is edge-detected there. All state and all mode outputs are registered. A synchronous active-high reset presets both the staging register and the latch to the default word 0x0400, in which only the mandatory bit 10 is set. A status output flags a latched word that breaks the encoding rules.

Top module: `cfg_serial_reg`

## Requirements
- R1: With select low, every rising edge of the serial clock shifts the data bit into the LSB of the staging register and moves the existing bits one place toward the MSB.
- R2: While select is high, the latched word (`cfg_word`) is loaded from the staging register on every system clock, so after a transfer it equals the shifted word.
- R3: The first bit shifted in ends up at bit 13 and the last at bit 0.
- R4: While select is low, `cfg_word` and all mode outputs keep their value, even when bits are being shifted.
- R5: `pwr_down` is 1 only when bits 1 and 2 are both 1. Every other combination of those two bits means normal operation.
- R6: Bit 4 drives `code_invert`, bit 6 drives `diff_out` and bit 9 drives `int_wclk`.
- R7: Bypass field {bit8,bit7}: 00 and 01 give no bypass, 10 sets `precomp_bypass`, and 11 sets `code_hiz`. The two outputs are never 1 together.
- R8: `enc_bypass` is 1 only when bit 11 is 1 and bits 7 and 8 are both 0.
- R9: `cfg_err` is 1 when latched bit 10 is 0, or when any of the reserved bits 0, 3, 5, 12 and 13 is 1.
- R10: Reset sets both the staging register and `cfg_word` to 0x0400. All mode outputs and `cfg_err` are then 0, including after a reset in mid-operation.
- R11: Serial-clock edges that arrive while select is high leave the staging register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sclk | input | 1 | Serial clock, asynchronous, active on its rising edge |
| cfg_sdata | input | 1 | Serial data, most significant bit first |
| cfg_load | input | 1 | Select: 0 = shift, 1 = transfer into the latch |
| cfg_word | output | 14 | Latched configuration word |
| pwr_down | output | 1 | Power-down mode selected |
| code_invert | output | 1 | Invert the code output |
| diff_out | output | 1 | Differential code output |
| precomp_bypass | output | 1 | Bypass write precompensation |
| code_hiz | output | 1 | Code output in high impedance |
| int_wclk | output | 1 | Use the internal write clock |
| enc_bypass | output | 1 | Pass data around the encoder |
| cfg_err | output | 1 | Latched word breaks the reserved-bit or fixed-one rule |

## Verification
The assertions check the cycle-level contract on every clock. They cover the shift step on a detected edge, the absence of any shift otherwise, the copy while select is high, and the latch hold while select is low. They also check that the decoded outputs and the error flag follow the previous cycle's latched word, and that the bypass outputs never conflict. Only the bench scenarios can show the end-to-end behaviour through the asynchronous serial wires. That covers the bit ordering of a whole word, the field meanings for chosen words, serial-clock edges ignored during a transfer, and the return to the default word after reset.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  localparam int CFG_W = 14;

  // bit positions whose meaning the downstream path depends on
  localparam int B_PD_LO   = 1;
  localparam int B_PD_HI   = 2;
  localparam int B_INV     = 4;
  localparam int B_DIFF    = 6;
  localparam int B_BYP_LO  = 7;
  localparam int B_BYP_HI  = 8;
  localparam int B_IWCLK   = 9;
  localparam int B_FIXED1  = 10;
  localparam int B_ENCBYP  = 11;

  localparam logic [CFG_W-1:0] RSV_MASK  = 14'b11_0000_0010_1001;
  localparam logic [CFG_W-1:0] CFG_RESET = 14'h0400;

  typedef struct packed {
    logic pwr_down;
    logic code_invert;
    logic diff_out;
    logic precomp_bypass;
    logic code_hiz;
    logic int_wclk;
    logic enc_bypass;
    logic cfg_err;
  } mode_t;

  function automatic mode_t decode_word(input logic [CFG_W-1:0] w);
    mode_t m;
    logic [1:0] byp;
    byp              = {w[B_BYP_HI], w[B_BYP_LO]};
    m.pwr_down       = w[B_PD_LO] & w[B_PD_HI];
    m.code_invert    = w[B_INV];
    m.diff_out       = w[B_DIFF];
    m.precomp_bypass = (byp == 2'b10);
    m.code_hiz       = (byp == 2'b11);
    m.int_wclk       = w[B_IWCLK];
    m.enc_bypass     = w[B_ENCBYP] & (byp == 2'b00);
    m.cfg_err        = ~w[B_FIXED1] | (|(w & RSV_MASK));
    return m;
  endfunction

endpackage

// File: rtl/cfg_sync_in.sv
module cfg_sync_in #(
  parameter int STAGES = 2,
  parameter int N      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cfg_shift_stage.sv
module cfg_shift_stage #(
  parameter int             W       = 14,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_s,
  input  logic         sdata_s,
  input  logic         load_s,
  output logic         sclk_rise,
  output logic [W-1:0] shreg
);

  logic sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev;

  always_ff @(posedge clk) begin
    if (rst)                       shreg <= RST_VAL;
    else if (sclk_rise && !load_s) shreg <= {shreg[W-2:0], sdata_s};
  end

endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import cfg_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VAL = CFG_RESET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_s,
  input  logic [CFG_W-1:0] shreg,
  output logic [CFG_W-1:0] word,
  output mode_t            modes
);

  always_ff @(posedge clk) begin
    if (rst)         word <= RST_VAL;
    else if (load_s) word <= shreg;
  end

  always_ff @(posedge clk) begin
    if (rst) modes <= decode_word(RST_VAL);
    else     modes <= decode_word(word);
  end

endmodule

// File: rtl/cfg_serial_reg.sv
module cfg_serial_reg
  import cfg_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [CFG_W-1:0] RST_VAL     = CFG_RESET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_sclk,
  input  logic             cfg_sdata,
  input  logic             cfg_load,
  output logic [CFG_W-1:0] cfg_word,
  output logic             pwr_down,
  output logic             code_invert,
  output logic             diff_out,
  output logic             precomp_bypass,
  output logic             code_hiz,
  output logic             int_wclk,
  output logic             enc_bypass,
  output logic             cfg_err
);

  localparam int NSIG = 3;

  logic [NSIG-1:0]  sync_q;
  logic             sclk_s, sd_s, sel_s;
  logic             sclk_rise;
  logic [CFG_W-1:0] shreg;
  mode_t            modes;

  cfg_sync_in #(.STAGES(SYNC_STAGES), .N(NSIG)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({cfg_load, cfg_sdata, cfg_sclk}),
    .q   (sync_q)
  );

  assign sclk_s = sync_q[0];
  assign sd_s   = sync_q[1];
  assign sel_s  = sync_q[2];

  cfg_shift_stage #(.W(CFG_W), .RST_VAL(RST_VAL)) shift_i (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (sclk_s),
    .sdata_s   (sd_s),
    .load_s    (sel_s),
    .sclk_rise (sclk_rise),
    .shreg     (shreg)
  );

  cfg_latch_bank #(.RST_VAL(RST_VAL)) latch_i (
    .clk    (clk),
    .rst    (rst),
    .load_s (sel_s),
    .shreg  (shreg),
    .word   (cfg_word),
    .modes  (modes)
  );

  assign pwr_down       = modes.pwr_down;
  assign code_invert    = modes.code_invert;
  assign diff_out       = modes.diff_out;
  assign precomp_bypass = modes.precomp_bypass;
  assign code_hiz       = modes.code_hiz;
  assign int_wclk       = modes.int_wclk;
  assign enc_bypass     = modes.enc_bypass;
  assign cfg_err        = modes.cfg_err;

endmodule

// File: rtl/cfg_serial_reg_chk.sv
module cfg_serial_reg_chk
  import cfg_pkg::*;
#(
  parameter int W = CFG_W
) (
  input logic         clk,
  input logic         rst,
  input logic         sel_s,
  input logic         sd_s,
  input logic         sclk_rise,
  input logic [W-1:0] shreg,
  input logic [W-1:0] cfg_word,
  input logic         pwr_down,
  input logic         precomp_bypass,
  input logic         code_hiz,
  input logic         enc_bypass,
  input logic         cfg_err
);

  assert_shift_step_R1: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !sel_s) |=> (shreg == {$past(shreg[W-2:0]), $past(sd_s)}));

  assert_no_shift_R11: assert property (@(posedge clk) disable iff (rst)
    (sel_s || !sclk_rise) |=> $stable(shreg));

  assert_transfer_R2: assert property (@(posedge clk) disable iff (rst)
    sel_s |=> (cfg_word == $past(shreg)));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> $stable(cfg_word));

  assert_pwr_follow_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pwr_down == ($past(cfg_word[B_PD_LO]) & $past(cfg_word[B_PD_HI]))));

  assert_bypass_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(precomp_bypass && code_hiz));

  assert_encbyp_clean_R8: assert property (@(posedge clk) disable iff (rst)
    enc_bypass |-> (!precomp_bypass && !code_hiz));

  assert_err_follow_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cfg_err == (!$past(cfg_word[B_FIXED1]) || ((($past(cfg_word)) & RSV_MASK) != '0))));

endmodule

bind cfg_serial_reg cfg_serial_reg_chk #(.W(cfg_pkg::CFG_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .sel_s          (sel_s),
  .sd_s           (sd_s),
  .sclk_rise      (sclk_rise),
  .shreg          (shreg),
  .cfg_word       (cfg_word),
  .pwr_down       (pwr_down),
  .precomp_bypass (precomp_bypass),
  .code_hiz       (code_hiz),
  .enc_bypass     (enc_bypass),
  .cfg_err        (cfg_err)
);

// File: tb/cfg_serial_reg_tb.sv
`timescale 1ns/1ps
module cfg_serial_reg_tb_top;

  localparam int HALF = 4;   // system clocks per serial half period

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_sclk = 1'b0;
  logic        cfg_sdata = 1'b0;
  logic        cfg_load = 1'b0;
  logic [13:0] cfg_word;
  logic        pwr_down, code_invert, diff_out, precomp_bypass;
  logic        code_hiz, int_wclk, enc_bypass, cfg_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  cfg_serial_reg dut_i (
    .clk(clk), .rst(rst), .cfg_sclk(cfg_sclk), .cfg_sdata(cfg_sdata),
    .cfg_load(cfg_load), .cfg_word(cfg_word), .pwr_down(pwr_down),
    .code_invert(code_invert), .diff_out(diff_out),
    .precomp_bypass(precomp_bypass), .code_hiz(code_hiz),
    .int_wclk(int_wclk), .enc_bypass(enc_bypass), .cfg_err(cfg_err)
  );

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // {pwr_down, code_invert, diff_out, precomp_bypass, code_hiz, int_wclk, enc_bypass, cfg_err}
  function automatic logic [7:0] outs();
    return {pwr_down, code_invert, diff_out, precomp_bypass, code_hiz,
            int_wclk, enc_bypass, cfg_err};
  endfunction

  task automatic shift_word(input logic [13:0] w);
    cfg_load = 1'b0;
    for (int i = 13; i >= 0; i--) begin
      cfg_sdata = w[i];
      wait_clks(HALF);
      cfg_sclk = 1'b1;
      wait_clks(HALF);
      cfg_sclk = 1'b0;
    end
    wait_clks(HALF);
  endtask

  task automatic transfer();
    cfg_load = 1'b1;
    wait_clks(6);
    cfg_load = 1'b0;
    wait_clks(6);
  endtask

  task automatic load_word(input logic [13:0] w);
    shift_word(w);
    transfer();
  endtask

  task automatic t_reset_state();
    check("R10 reset word", cfg_word, 14'h0400);
    check("R10 reset outputs", outs(), 8'h00);
  endtask

  task automatic t_order();
    load_word(14'h2A55);
    check("R1 R3 shifted word order", cfg_word, 14'h2A55);
    load_word(14'h0601);
    check("R3 last bit lands at bit 0", cfg_word, 14'h0601);
  endtask

  task automatic t_hold();
    load_word(14'h0450);
    shift_word(14'h0586);
    check("R4 word held while shifting", cfg_word, 14'h0450);
    check("R4 outputs held while shifting", outs(), 8'b0110_0000);
    transfer();
    check("R2 word after transfer", cfg_word, 14'h0586);
    check("R2 outputs after transfer", outs(), 8'b1000_1000);
  endtask

  task automatic t_power();
    load_word(14'h0406);
    check("R5 both power bits", outs(), 8'b1000_0000);
    load_word(14'h0402);
    check("R5 one power bit", outs(), 8'b0000_0000);
    load_word(14'h0404);
    check("R5 other power bit", outs(), 8'b0000_0000);
  endtask

  task automatic t_single_bits();
    load_word(14'h0410);
    check("R6 invert bit4", outs(), 8'b0100_0000);
    load_word(14'h0440);
    check("R6 differential bit6", outs(), 8'b0010_0000);
    load_word(14'h0600);
    check("R6 internal wclk bit9", outs(), 8'b0000_0100);
  endtask

  task automatic t_bypass();
    load_word(14'h0500);
    check("R7 field 10 precomp bypass", outs(), 8'b0001_0000);
    load_word(14'h0580);
    check("R7 field 11 high-z", outs(), 8'b0000_1000);
    load_word(14'h0480);
    check("R7 field 01 no bypass", outs(), 8'b0000_0000);
  endtask

  task automatic t_encbyp();
    load_word(14'h0C00);
    check("R8 encoder bypass active", outs(), 8'b0000_0010);
    load_word(14'h0D00);
    check("R8 encoder bypass blocked by field", outs(), 8'b0001_0000);
    load_word(14'h0C80);
    check("R8 encoder bypass blocked by bit7", outs(), 8'b0000_0000);
  endtask

  task automatic t_err();
    load_word(14'h0000);
    check("R9 fixed bit clear", cfg_err, 1'b1);
    load_word(14'h0401);
    check("R9 reserved bit0", cfg_err, 1'b1);
    load_word(14'h2400);
    check("R9 reserved bit13", cfg_err, 1'b1);
    load_word(14'h0428);
    check("R9 reserved bits 3 and 5", cfg_err, 1'b1);
    load_word(14'h1400);
    check("R9 reserved bit12", cfg_err, 1'b1);
    load_word(14'h0400);
    check("R9 legal word", cfg_err, 1'b0);
  endtask

  task automatic t_ignore_edges();
    load_word(14'h0446);
    cfg_load  = 1'b1;
    cfg_sdata = 1'b1;
    wait_clks(6);
    for (int i = 0; i < 3; i++) begin
      cfg_sclk = 1'b1;
      wait_clks(HALF);
      cfg_sclk = 1'b0;
      wait_clks(HALF);
    end
    cfg_load = 1'b0;
    wait_clks(6);
    transfer();
    check("R11 edges during transfer ignored", cfg_word, 14'h0446);
  endtask

  task automatic t_mid_reset();
    load_word(14'h0446);
    shift_word(14'h3FFF);
    @(negedge clk) rst = 1'b1;
    wait_clks(2);
    rst = 1'b0;
    wait_clks(3);
    check("R10 reset word after use", cfg_word, 14'h0400);
    check("R10 reset outputs after use", outs(), 8'h00);
    transfer();
    check("R10 staging preset by reset", cfg_word, 14'h0400);
  endtask

  initial begin
    wait_clks(4);
    rst = 1'b0;
    wait_clks(2);
    t_reset_state();
    t_order();
    t_hold();
    t_power();
    t_single_bits();
    t_bypass();
    t_encbyp();
    t_err();
    t_ignore_edges();
    t_mid_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait_clks(100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule